// File: doc/BRIEF.md
# Peak Finder and Truncation Unit

This block runs once over a sample buffer that has already been filled. It reads every location, from the lowest address up to the highest, and finds the largest sample and the address where it sits. It then turns that address into a truncation point. Downstream demodulation begins reading at the peak, and every sample stored below the peak is dropped. Each acquisition can begin at a different point of the carrier waveform. Cutting the window at its maximum makes the retained data begin at the same phase of the common carrier period every time.

A single start pulse launches a scan. The block drives a synchronous read port of the sample RAM, one address per cycle. Read data returns after a fixed number of cycles, set by a parameter, and a tag pipeline pairs each returned sample with the address it came from. When the scan ends, the block publishes the peak value, the peak address, the truncated start address and the remaining length. A one-cycle done pulse marks them valid, and they keep their values until the next scan updates them.

Top module: `peak_trunc_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `done_o`, `busy_o` and `rd_en_o` are 0, and `peak_val_o`, `peak_addr_o`, `trunc_start_o` and `trunc_len_o` are all 0.
- R2: A start accepted while idle produces exactly DEPTH read cycles, with `rd_en_o` high on each. The addresses run 0, 1, …, DEPTH-1, one per consecutive cycle, beginning in the cycle after the start is sampled.
- R3: `peak_val_o` is the largest sample in the buffer when samples are compared as signed two's-complement numbers (with SIGNED_CMP=1, the default). `peak_addr_o` is that sample's address.
- R4: When the largest value occurs at several addresses, `peak_addr_o` reports the lowest of them. A later sample replaces the running maximum only when it is strictly greater.
- R5: The sample at address 0 seeds the running maximum. If it is the largest sample, the results are address 0 and length DEPTH.
- R6: `trunc_start_o` equals `peak_addr_o`, and `trunc_len_o` equals DEPTH minus `peak_addr_o`. A peak at the last address gives a length of 1.
- R7: `done_o` is high for exactly one cycle. Its rising edge comes DEPTH+RD_LAT clock edges after the edge that sampled the start. The four results stay constant from that point until the next scan ends.
- R8: A start pulse that arrives while `busy_o` is high is ignored. The scan in progress neither restarts nor ends early, and only one done pulse follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Reset, active low, synchronous |
| start_i | input | 1 | Starts a scan when the block is idle |
| rd_en_o | output | 1 | Read enable to the sample RAM |
| rd_addr_o | output | ADDR_W | Read address to the sample RAM |
| rd_data_i | input | DATA_W | Read data, RD_LAT cycles after the address |
| busy_o | output | 1 | High while a scan is in progress |
| done_o | output | 1 | One-cycle pulse when the results are valid |
| peak_val_o | output | DATA_W | Largest sample found |
| peak_addr_o | output | ADDR_W | Address of the first occurrence of the largest sample |
| trunc_start_o | output | ADDR_W | First address that downstream processing keeps |
| trunc_len_o | output | LEN_W | Number of samples kept from the truncated start address onward |

## Verification
The first read address is due one edge after the start is sampled. Each later address follows one edge after the previous one. A monitor checks every read cycle against a counter that advances in step. The done pulse is due DEPTH+RD_LAT edges after the start edge. The bench counts edges from the start edge, sampling on the falling edge, and requires done to be low before that count, high at it, and low on the edge after it. The results are compared in the done cycle and again several cycles later, so a value that is published early or disturbed after done is caught.

// File: rtl/ptu_pkg.sv
package ptu_pkg;

   typedef enum logic [0:0] {
      PTU_IDLE = 1'b0,
      PTU_SCAN = 1'b1
   } ptu_state_e;

endpackage

// File: rtl/ptu_addr_gen.sv
module ptu_addr_gen #(
   parameter int unsigned DEPTH  = 512,
   parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   output logic              rd_en_o,
   output logic [ADDR_W-1:0] rd_addr_o
);

   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

   logic              active_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         addr_q   <= '0;
      end else if (go_i) begin
         active_q <= 1'b1;
         addr_q   <= '0;
      end else if (active_q) begin
         if (addr_q == LAST_ADDR) begin
            active_q <= 1'b0;
         end else begin
            addr_q <= addr_q + 1'b1;
         end
      end
   end

   assign rd_en_o   = active_q;
   assign rd_addr_o = addr_q;

endmodule

// File: rtl/ptu_tag_pipe.sv
module ptu_tag_pipe #(
   parameter int unsigned ADDR_W = 9,
   parameter int unsigned RD_LAT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              vld_o,
   output logic [ADDR_W-1:0] addr_o
);

   generate
      if (RD_LAT == 0) begin : g_bypass
         assign vld_o  = vld_i;
         assign addr_o = addr_i;
      end else begin : g_stages
         logic              vld_q  [RD_LAT];
         logic [ADDR_W-1:0] addr_q [RD_LAT];

         for (genvar s = 0; s < RD_LAT; s++) begin : g_stage
            if (s == 0) begin : g_head
               always_ff @(posedge clk) begin
                  if (!rst_n) begin
                     vld_q[0]  <= 1'b0;
                     addr_q[0] <= '0;
                  end else begin
                     vld_q[0]  <= vld_i;
                     addr_q[0] <= addr_i;
                  end
               end
            end else begin : g_body
               always_ff @(posedge clk) begin
                  if (!rst_n) begin
                     vld_q[s]  <= 1'b0;
                     addr_q[s] <= '0;
                  end else begin
                     vld_q[s]  <= vld_q[s-1];
                     addr_q[s] <= addr_q[s-1];
                  end
               end
            end
         end

         assign vld_o  = vld_q[RD_LAT-1];
         assign addr_o = addr_q[RD_LAT-1];
      end
   endgenerate

endmodule

// File: rtl/ptu_max_track.sv
module ptu_max_track #(
   parameter int unsigned DEPTH      = 512,
   parameter int unsigned DATA_W     = 12,
   parameter bit          SIGNED_CMP = 1'b1,
   parameter int unsigned ADDR_W     = $clog2(DEPTH),
   parameter int unsigned LEN_W      = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] sample_i,
   output logic              final_o,
   output logic              done_o,
   output logic [DATA_W-1:0] peak_val_o,
   output logic [ADDR_W-1:0] peak_addr_o,
   output logic [LEN_W-1:0]  trunc_len_o
);

   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
   localparam logic [LEN_W-1:0]  FULL_LEN  = LEN_W'(DEPTH);

   logic [DATA_W-1:0] best_q;
   logic [ADDR_W-1:0] best_addr_q;
   logic              greater;
   logic              take;
   logic              first;
   logic [DATA_W-1:0] nxt_best;
   logic [ADDR_W-1:0] nxt_addr;

   generate
      if (SIGNED_CMP) begin : g_cmp_signed
         assign greater = $signed(sample_i) > $signed(best_q);
      end else begin : g_cmp_unsigned
         assign greater = sample_i > best_q;
      end
   endgenerate

   assign first   = (addr_i == '0);
   assign take    = first || greater;
   assign final_o = vld_i && (addr_i == LAST_ADDR);

   always_comb begin
      nxt_best = best_q;
      nxt_addr = best_addr_q;
      if (take) begin
         nxt_best = sample_i;
         nxt_addr = addr_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         best_q      <= '0;
         best_addr_q <= '0;
      end else if (vld_i) begin
         best_q      <= nxt_best;
         best_addr_q <= nxt_addr;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_o      <= 1'b0;
         peak_val_o  <= '0;
         peak_addr_o <= '0;
         trunc_len_o <= '0;
      end else begin
         done_o <= final_o;
         if (final_o) begin
            peak_val_o  <= nxt_best;
            peak_addr_o <= nxt_addr;
            trunc_len_o <= FULL_LEN - LEN_W'(nxt_addr);
         end
      end
   end

endmodule

// File: rtl/peak_trunc_unit.sv
module peak_trunc_unit #(
   parameter int unsigned DEPTH      = 512,
   parameter int unsigned DATA_W     = 12,
   parameter int unsigned RD_LAT     = 1,
   parameter bit          SIGNED_CMP = 1'b1,
   parameter int unsigned ADDR_W     = $clog2(DEPTH),
   parameter int unsigned LEN_W      = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   output logic              rd_en_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] peak_val_o,
   output logic [ADDR_W-1:0] peak_addr_o,
   output logic [ADDR_W-1:0] trunc_start_o,
   output logic [LEN_W-1:0]  trunc_len_o
);

   import ptu_pkg::*;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("peak_trunc_unit: DEPTH must be at least 2");
      end
      if ((1 << ADDR_W) < DEPTH) begin : g_bad_addr
         $error("peak_trunc_unit: ADDR_W too narrow for DEPTH");
      end
      if (RD_LAT > 4) begin : g_bad_lat
         $error("peak_trunc_unit: RD_LAT must be 0 to 4");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("peak_trunc_unit: DATA_W must be at least 2");
      end
   endgenerate

   ptu_state_e        state_q;
   logic              go;
   logic              final_cmp;
   logic              tag_vld;
   logic [ADDR_W-1:0] tag_addr;

   assign go = start_i && (state_q == PTU_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= PTU_IDLE;
      end else begin
         case (state_q)
            PTU_IDLE: if (go)        state_q <= PTU_SCAN;
            PTU_SCAN: if (final_cmp) state_q <= PTU_IDLE;
            default:                 state_q <= PTU_IDLE;
         endcase
      end
   end

   assign busy_o = (state_q == PTU_SCAN);

   ptu_addr_gen #(
      .DEPTH  (DEPTH),
      .ADDR_W (ADDR_W)
   ) addr_gen_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .go_i      (go),
      .rd_en_o   (rd_en_o),
      .rd_addr_o (rd_addr_o)
   );

   ptu_tag_pipe #(
      .ADDR_W (ADDR_W),
      .RD_LAT (RD_LAT)
   ) tag_pipe_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld_i  (rd_en_o),
      .addr_i (rd_addr_o),
      .vld_o  (tag_vld),
      .addr_o (tag_addr)
   );

   ptu_max_track #(
      .DEPTH      (DEPTH),
      .DATA_W     (DATA_W),
      .SIGNED_CMP (SIGNED_CMP),
      .ADDR_W     (ADDR_W),
      .LEN_W      (LEN_W)
   ) max_track_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .vld_i       (tag_vld),
      .addr_i      (tag_addr),
      .sample_i    (rd_data_i),
      .final_o     (final_cmp),
      .done_o      (done_o),
      .peak_val_o  (peak_val_o),
      .peak_addr_o (peak_addr_o),
      .trunc_len_o (trunc_len_o)
   );

   assign trunc_start_o = peak_addr_o;

endmodule

// File: rtl/ptu_chk.sv
module ptu_chk #(
   parameter int unsigned DEPTH  = 512,
   parameter int unsigned DATA_W = 12,
   parameter int unsigned ADDR_W = $clog2(DEPTH),
   parameter int unsigned LEN_W  = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              rd_en_o,
   input logic [ADDR_W-1:0] rd_addr_o,
   input logic              busy_o,
   input logic              done_o,
   input logic [DATA_W-1:0] peak_val_o,
   input logic [ADDR_W-1:0] peak_addr_o,
   input logic [ADDR_W-1:0] trunc_start_o,
   input logic [LEN_W-1:0]  trunc_len_o
);

   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
   localparam logic [LEN_W:0]    FULL_SUM  = (LEN_W + 1)'(DEPTH);

   // R2
   first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (rd_en_o && rd_addr_o == '0));

   // R2
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_o && rd_addr_o != LAST_ADDR) |=>
         (rd_en_o && rd_addr_o == $past(rd_addr_o) + 1'b1));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R6
   len_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (({1'b0, trunc_len_o} + (LEN_W + 1)'(trunc_start_o)) == FULL_SUM));

   // R6
   start_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (trunc_start_o == peak_addr_o));

   // R7
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |=> ($stable(peak_val_o) && $stable(peak_addr_o) && $stable(trunc_len_o)));

   // R8
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_o && rd_addr_o != LAST_ADDR) |=> !(rd_addr_o == '0));

endmodule

bind peak_trunc_unit ptu_chk #(
   .DEPTH  (DEPTH),
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .LEN_W  (LEN_W)
) ptu_chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .start_i       (start_i),
   .rd_en_o       (rd_en_o),
   .rd_addr_o     (rd_addr_o),
   .busy_o        (busy_o),
   .done_o        (done_o),
   .peak_val_o    (peak_val_o),
   .peak_addr_o   (peak_addr_o),
   .trunc_start_o (trunc_start_o),
   .trunc_len_o   (trunc_len_o)
);

// File: tb/peak_trunc_unit_tb_top.sv
module peak_trunc_unit_tb_top;

   localparam int D      = 32;
   localparam int DW     = 12;
   localparam int AW     = $clog2(D);
   localparam int LW     = $clog2(D + 1);
   localparam int LAT    = 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          rd_en;
   logic [AW-1:0] rd_addr;
   logic [DW-1:0] rd_data = '0;
   logic          busy, done;
   logic [DW-1:0] peak_val;
   logic [AW-1:0] peak_addr, trunc_start;
   logic [LW-1:0] trunc_len;

   logic signed [DW-1:0] mem [D];

   int n_tests = 0;
   int n_fail  = 0;
   int mon_err = 0;
   int rd_cnt  = 0;
   int exp_a   = 0;

   always #2.5 clk = ~clk;

   peak_trunc_unit #(
      .DEPTH (D), .DATA_W (DW), .RD_LAT (LAT)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .start_i (start),
      .rd_en_o (rd_en), .rd_addr_o (rd_addr), .rd_data_i (rd_data),
      .busy_o (busy), .done_o (done), .peak_val_o (peak_val),
      .peak_addr_o (peak_addr), .trunc_start_o (trunc_start),
      .trunc_len_o (trunc_len)
   );

   // sample RAM model, one cycle read latency
   always @(posedge clk) begin
      if (rd_en) rd_data <= mem[rd_addr];
   end

   // read-order monitor for R2
   always @(posedge clk) begin
      if (rst_n && start && !busy) begin
         rd_cnt = 0;
         exp_a  = 0;
      end else if (rst_n && rd_en) begin
         if (int'(rd_addr) != exp_a) mon_err = mon_err + 1;
         exp_a  = exp_a + 1;
         rd_cnt = rd_cnt + 1;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // runs a scan; returns edges from start edge to done, optional extra start at edge k
   task automatic run_scan(output int cyc, input int extra_at);
      cyc = 0;
      @(negedge clk) start = 1'b1;
      @(posedge clk);
      @(negedge clk) start = 1'b0;
      for (int i = 1; i <= 4 * D; i++) begin
         @(posedge clk);
         @(negedge clk);
         start = (i == extra_at);
         if (done) begin
            cyc = i;
            break;
         end
      end
      start = 1'b0;
   endtask

   task automatic check_result(input string tag, input int ev, input int ea);
      chk($signed(peak_val) == ev, {tag, " R3 peak value"}, int'($signed(peak_val)), ev);
      chk(int'(peak_addr) == ea, {tag, " R3 R4 peak addr"}, int'(peak_addr), ea);
      chk(int'(trunc_start) == ea, {tag, " R6 trunc start"}, int'(trunc_start), ea);
      chk(int'(trunc_len) == D - ea, {tag, " R6 trunc len"}, int'(trunc_len), D - ea);
   endtask

   task automatic check_timing(input string tag, input int cyc);
      chk(cyc == D + LAT, {tag, " R7 done latency"}, cyc, D + LAT);
      chk(rd_cnt == D, {tag, " R2 read count"}, rd_cnt, D);
      chk(mon_err == 0, {tag, " R2 read order"}, mon_err, 0);
      @(negedge clk);
      chk(!done, {tag, " R7 done single cycle"}, int'(done), 0);
   endtask

   task automatic t_reset();
      chk(!done && !busy && !rd_en, "R1 control idle", int'({done, busy, rd_en}), 0);
      chk(peak_val == '0 && peak_addr == '0 && trunc_len == '0 && trunc_start == '0,
          "R1 results zero", int'(peak_val) + int'(trunc_len), 0);
   endtask

   task automatic t_ramp();
      int cyc;
      for (int i = 0; i < D; i++) mem[i] = DW'(i * 3 - 40);
      mon_err = 0;
      run_scan(cyc, 0);
      check_result("ramp", (D - 1) * 3 - 40, D - 1);
      check_timing("ramp", cyc);
   endtask

   task automatic t_first();
      int cyc;
      for (int i = 0; i < D; i++) mem[i] = DW'(100 - i);
      mon_err = 0;
      run_scan(cyc, 0);
      check_result("R5 seed", 100, 0);
      check_timing("R5 seed", cyc);
   endtask

   task automatic t_mixed();
      int cyc;
      for (int i = 0; i < D; i++) mem[i] = DW'(((i * 37) % 29) * 11 - 150);
      mem[13] = DW'(900);
      mon_err = 0;
      run_scan(cyc, 0);
      check_result("mixed", 900, 13);
      check_timing("mixed", cyc);
   endtask

   task automatic t_ties();
      int cyc;
      for (int i = 0; i < D; i++) mem[i] = DW'(5);
      mem[7]  = DW'(77);
      mem[20] = DW'(77);
      mem[29] = DW'(77);
      mon_err = 0;
      run_scan(cyc, 0);
      check_result("R4 ties", 77, 7);
   endtask

   task automatic t_signed();
      int cyc;
      for (int i = 0; i < D; i++) mem[i] = -DW'(1);
      mem[4] = DW'(5);
      mon_err = 0;
      run_scan(cyc, 0);
      check_result("R3 signed", 5, 4);
   endtask

   task automatic t_restart();
      int cyc;
      for (int i = 0; i < D; i++) mem[i] = DW'(i % 9);
      mem[22] = DW'(300);
      mon_err = 0;
      run_scan(cyc, 6);
      chk(cyc == D + LAT, "R8 restart ignored latency", cyc, D + LAT);
      chk(rd_cnt == D && mon_err == 0, "R8 single read pass", rd_cnt, D);
      check_result("R8 restart", 300, 22);
      // R7 hold: no further done, results unchanged
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (done) chk(0, "R8 R7 extra done", 1, 0);
      end
      chk(int'(peak_addr) == 22 && int'(trunc_len) == D - 22, "R7 results held",
          int'(peak_addr), 22);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < D; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ramp();
      t_first();
      t_mixed();
      t_ties();
      t_signed();
      t_restart();
      repeat (3) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule